// File: doc/BRIEF.md
# Self-Stalling Functional Unit Pipeline

This block models the timing of one execution functional unit as a fixed-length chain of stages. An issuing stage pushes an opaque instruction tag into the first stage; a per-cycle advance strobe moves every entry one stage toward the far end. The chain behaves like a delay line until an entry reaches the last stage. From then on that entry is held, and the chain refuses to move, until the consuming commit logic pops it. An advance that is refused raises a sticky stalled flag. The flag stays visible until the held entry is popped.

Entry into the unit is throttled in two ways. A push is refused while the first stage would remain occupied after this cycle's movement. A push is also refused while an issue-interval counter, reloaded on every accepted push, has not yet run out. Empty stages carry a bubble, which is a cleared valid bit with an all-zero tag, and is never confused with a real entry. A busy output tells the surrounding scheduler that work is still in flight, so the unit needs evaluating next cycle. The depth (issue-to-output latency, at least 2) and the minimum issue interval are parameters.

Top module: `fu_sspipe`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, stalled and busy are 0, out_tag is 0, and push_ready is 1.
- R2: With advance held high every cycle and nothing held at the output, a tag pushed in cycle t appears with out_valid=1 in cycle t+DEPTH, and the order of entries is kept.
- R3: An advance with out_valid=1 and pop=0 moves no entry: out_valid and out_tag are unchanged in the next cycle and stalled is 1.
- R4: stalled, once set, stays 1 until a pop is made while out_valid=1. A pop without advance empties the output stage and clears stalled in the next cycle, without moving any other entry.
- R5: A pop together with advance while out_valid=1 removes the output entry and shifts all others one stage in the same cycle, and stalled is 0 afterwards.
- R6: push_ready is 0 whenever the first stage is occupied and no shift happens this cycle.
- R7: After an accepted push, push_ready stays 0 for the next ISSUE_GAP-1 cycles, whatever the state of the stages.
- R8: Whenever out_valid is 0, out_tag is all zeros (bubble value).
- R9: busy is 1 exactly when at least one stage holds a valid entry.
- R10: A push offered while push_ready is 0 is dropped: the tag never enters the pipeline and never appears at the output.
- R11: A pop while out_valid is 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Issue side offers a tag this cycle |
| push_tag | input | TAG_W | Instruction tag to enter the first stage |
| push_ready | output | 1 | Offered tag is accepted at this clock edge |
| advance | input | 1 | Request to move all entries one stage |
| pop | input | 1 | Commit side consumes the entry at the output stage |
| out_valid | output | 1 | Output stage holds a valid entry |
| out_tag | output | TAG_W | Tag at the output stage, zero when empty |
| stalled | output | 1 | An advance was refused and the output entry is not yet consumed |
| busy | output | 1 | Any stage holds a valid entry |

## Verification
The bench goes after the moment an entry first lands in the last stage. A design that lets a following advance push it out would lose an instruction, and one that overwrites it would corrupt the held tag. A pop in the same cycle as an advance must shift and clear the stall together. A design that handles these one after the other would lose a cycle or leave stalled stuck. Pushes are offered into an occupied first stage and inside the issue interval: a wrong gate either admits a tag that should be dropped, which later shows up at the output, or refuses a legal issue. Long pseudo-random runs of push, advance and pop are compared each cycle against a queue-based model. This catches an off-by-one in latency, in stall release, or in the interval counter.

// File: rtl/fu_pipe_pkg.sv
package fu_pipe_pkg;

  // What an advance request does in the current cycle.
  typedef enum logic [1:0] {
    ADV_NONE    = 2'd0,  // no advance requested
    ADV_MOVE    = 2'd1,  // output empty, chain shifts
    ADV_BLOCK   = 2'd2,  // output held, chain frozen
    ADV_HANDOFF = 2'd3   // output popped, chain shifts in same cycle
  } adv_kind_e;

  function automatic adv_kind_e classify_advance(input logic adv,
                                                 input logic out_v,
                                                 input logic pop_req);
    if (!adv)    return ADV_NONE;
    if (!out_v)  return ADV_MOVE;
    if (pop_req) return ADV_HANDOFF;
    return ADV_BLOCK;
  endfunction

  function automatic logic chain_moves(input adv_kind_e kind);
    return (kind == ADV_MOVE) || (kind == ADV_HANDOFF);
  endfunction

  function automatic logic stall_next(input logic cur,
                                      input adv_kind_e kind,
                                      input logic drained);
    if (kind == ADV_BLOCK) return 1'b1;
    if (drained)           return 1'b0;
    return cur;
  endfunction

  function automatic logic may_enter(input logic gap_open,
                                     input logic first_busy,
                                     input logic moving);
    return gap_open && (!first_busy || moving);
  endfunction

endpackage

// File: rtl/fu_issue_gate.sv
module fu_issue_gate #(
  parameter int ISSUE_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic gap_open
);
  localparam int GAP_W = (ISSUE_GAP > 1) ? $clog2(ISSUE_GAP) : 1;
  localparam logic [GAP_W-1:0] RELOAD = GAP_W'(ISSUE_GAP - 1);

  logic [GAP_W-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_q <= '0;
    else if (fire)           wait_q <= RELOAD;
    else if (wait_q != '0)   wait_q <= wait_q - GAP_W'(1);
  end

  assign gap_open = (wait_q == '0);
endmodule

// File: rtl/fu_stage_chain.sv
module fu_stage_chain #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             load_en,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             drain_en,
  output logic             first_occ,
  output logic             last_vld,
  output logic [TAG_W-1:0] last_tag,
  output logic             any_vld
);
  localparam int LAST = DEPTH - 1;

  logic             vld [DEPTH];
  logic [TAG_W-1:0] tg  [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[s] <= 1'b0;
          tg[s]  <= '0;
        end else if (shift_en || load_en) begin
          vld[s] <= load_en;
          tg[s]  <= load_en ? load_tag : '0;
        end
      end
    end else if (s == LAST) begin : g_exit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[s] <= 1'b0;
          tg[s]  <= '0;
        end else if (shift_en) begin
          vld[s] <= vld[s-1];
          tg[s]  <= tg[s-1];
        end else if (drain_en) begin
          vld[s] <= 1'b0;
          tg[s]  <= '0;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[s] <= 1'b0;
          tg[s]  <= '0;
        end else if (shift_en) begin
          vld[s] <= vld[s-1];
          tg[s]  <= tg[s-1];
        end
      end
    end
  end

  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < DEPTH; s++) any_vld = any_vld | vld[s];
  end

  assign first_occ = vld[0];
  assign last_vld  = vld[LAST];
  assign last_tag  = tg[LAST];
endmodule

// File: rtl/fu_sspipe.sv
module fu_sspipe
  import fu_pipe_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int TAG_W     = 8,
  parameter int ISSUE_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [TAG_W-1:0] push_tag,
  output logic             push_ready,
  input  logic             advance,
  input  logic             pop,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic             stalled,
  output logic             busy
);
  // Named internal events, brought out for the checker.
  adv_kind_e adv_kind;
  logic      shift_en;
  logic      push_fire;
  logic      pop_fire;
  logic      gap_open;
  logic      in_occ;
  logic      stall_q;

  assign adv_kind   = classify_advance(advance, out_valid, pop);
  assign shift_en   = chain_moves(adv_kind);
  assign pop_fire   = pop && out_valid;
  assign push_ready = may_enter(gap_open, in_occ, shift_en);
  assign push_fire  = push_valid && push_ready;

  fu_issue_gate #(.ISSUE_GAP(ISSUE_GAP)) gate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (push_fire),
    .gap_open (gap_open)
  );

  fu_stage_chain #(.DEPTH(DEPTH), .TAG_W(TAG_W)) chain_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .load_en   (push_fire),
    .load_tag  (push_tag),
    .drain_en  (pop_fire),
    .first_occ (in_occ),
    .last_vld  (out_valid),
    .last_tag  (out_tag),
    .any_vld   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall_next(stall_q, adv_kind, pop_fire);
  end

  assign stalled = stall_q;
endmodule

// File: rtl/fu_sspipe_chk.sv
module fu_sspipe_chk #(
  parameter int TAG_W     = 8,
  parameter int ISSUE_GAP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             advance,
  input logic             pop,
  input logic             push_ready,
  input logic             push_fire,
  input logic             out_valid,
  input logic [TAG_W-1:0] out_tag,
  input logic             stalled,
  input logic             busy,
  input logic             in_occ,
  input logic             shift_en
);
  assert_reset_clean_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !stalled && !out_valid);

  assert_block_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance && out_valid && !pop |=> stalled && out_valid && $stable(out_tag));

  assert_pop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop && out_valid && !advance |=> !stalled && !out_valid);

  assert_stall_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stalled && !pop |=> stalled);

  assert_handoff_nostall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance && pop && out_valid |=> !stalled);

  assert_occupied_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_occ && !shift_en |-> !push_ready);

  if (ISSUE_GAP > 1) begin : g_gap
    assert_issue_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push_fire |=> !push_ready);
  end

  assert_bubble_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_tag == '0);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid || in_occ |-> busy);
endmodule

bind fu_sspipe fu_sspipe_chk #(.TAG_W(TAG_W), .ISSUE_GAP(ISSUE_GAP)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .advance    (advance),
  .pop        (pop),
  .push_ready (push_ready),
  .push_fire  (push_fire),
  .out_valid  (out_valid),
  .out_tag    (out_tag),
  .stalled    (stalled),
  .busy       (busy),
  .in_occ     (in_occ),
  .shift_en   (shift_en)
);

// File: tb/fu_sspipe_tb_top.sv
module fu_sspipe_tb_top;
  localparam int DEPTH = 4;
  localparam int TAG_W = 8;
  localparam int GAP   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push_valid = 1'b0;
  logic [TAG_W-1:0] push_tag = '0;
  logic             push_ready;
  logic             advance = 1'b0;
  logic             pop = 1'b0;
  logic             out_valid;
  logic [TAG_W-1:0] out_tag;
  logic             stalled;
  logic             busy;

  always #4 clk = ~clk;  // 125 MHz

  fu_sspipe #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ISSUE_GAP(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_tag(push_tag),
    .push_ready(push_ready), .advance(advance), .pop(pop),
    .out_valid(out_valid), .out_tag(out_tag), .stalled(stalled), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  // Reference model: entries as (position, tag) pairs, position 0 = entry side.
  int q_pos[$];
  int q_tag[$];
  int m_gap = 0;
  bit m_stall = 0;
  bit last_ready;
  int seen_tags[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit occ(int p);
    foreach (q_pos[i]) if (q_pos[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int tag_at(int p);
    foreach (q_pos[i]) if (q_pos[i] == p) return q_tag[i];
    return 0;
  endfunction

  task automatic step(bit pv, int tg, bit adv, bit pp);
    bit shift, exp_ready, accept, popd, out_occ;
    @(negedge clk);
    push_valid = pv; push_tag = TAG_W'(tg); advance = adv; pop = pp;
    #1;
    out_occ   = occ(DEPTH-1);
    shift     = adv && (!out_occ || pp);
    exp_ready = (m_gap == 0) && (!occ(0) || shift);
    last_ready = push_ready;
    if (m_gap != 0) chk("R7", "push_ready in interval", int'(push_ready), int'(exp_ready));
    else            chk("R6", "push_ready", int'(push_ready), int'(exp_ready));
    chk("R2", "out_valid", int'(out_valid), int'(out_occ));
    chk("R8", "out_tag", int'(out_tag), tag_at(DEPTH-1));
    chk("R9", "busy", int'(busy), int'(q_pos.size() != 0));
    chk("R4", "stalled", int'(stalled), int'(m_stall));
    if (out_valid) seen_tags.push_back(int'(out_tag));
    // model update for the coming edge
    accept = pv && exp_ready;
    popd   = pp && out_occ;
    if (adv && out_occ && !pp) m_stall = 1'b1;
    else if (popd)             m_stall = 1'b0;
    if (popd) begin
      for (int i = 0; i < q_pos.size(); i++)
        if (q_pos[i] == DEPTH-1) begin q_pos.delete(i); q_tag.delete(i); break; end
    end
    if (shift) foreach (q_pos[i]) q_pos[i]++;
    if (accept) begin q_pos.push_back(0); q_tag.push_back(tg); end
    if (accept) m_gap = GAP - 1;
    else if (m_gap > 0) m_gap--;
    @(posedge clk);
    #1;
    push_valid = 1'b0; advance = 1'b0; pop = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit found;
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "stalled after reset", int'(stalled), 0);
    chk("R1", "out_tag after reset", int'(out_tag), 0);
    chk("R1", "push_ready after reset", int'(push_ready), 1);

    // R2 latency with continuous advance
    step(1, 'h11, 1, 0);
    for (int k = 0; k < DEPTH-1; k++) step(0, 0, 1, 0);
    chk("R2", "out_valid after DEPTH", int'(out_valid), 1);
    chk("R2", "out_tag after DEPTH", int'(out_tag), 'h11);

    // R3 blocked advance holds output
    step(0, 0, 1, 0);
    chk("R3", "stalled after blocked advance", int'(stalled), 1);
    chk("R3", "out_tag held", int'(out_tag), 'h11);
    step(1, 'h22, 0, 0);          // accepted into first stage
    step(0, 0, 1, 0);             // blocked again
    step(1, 'h33, 0, 0);          // first stage occupied: refused
    chk("R6", "push into occupied stage", int'(last_ready), 0);
    step(1, 'h44, 1, 0);          // advance blocked, stage still occupied
    chk("R6", "push during blocked advance", int'(last_ready), 0);
    chk("R4", "stall persists without pop", int'(stalled), 1);

    // R4 pop without advance
    step(0, 0, 0, 1);
    chk("R4", "stalled after pop", int'(stalled), 0);
    chk("R4", "out_valid after pop", int'(out_valid), 0);
    chk("R4", "other entry kept", int'(busy), 1);
    for (int k = 0; k < DEPTH-1; k++) step(0, 0, 1, 0);
    chk("R4", "first-stage entry not moved by pop", int'(out_tag), 'h22);
    step(0, 0, 0, 1);

    // R5 handoff of adjacent entries
    step(1, 'h70, 0, 0);
    step(0, 0, 0, 0);
    step(1, 'h71, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R5", "head at output", int'(out_tag), 'h70);
    step(0, 0, 1, 1);
    chk("R5", "next entry at output", int'(out_tag), 'h71);
    chk("R5", "out_valid after handoff", int'(out_valid), 1);
    chk("R5", "stalled after handoff", int'(stalled), 0);
    step(0, 0, 0, 1);

    // R11 pop on empty output
    step(0, 0, 0, 1);
    chk("R11", "out_valid after empty pop", int'(out_valid), 0);
    chk("R11", "busy after empty pop", int'(busy), 0);
    chk("R11", "stalled after empty pop", int'(stalled), 0);

    // R7 issue interval
    step(1, 'h80, 1, 0);
    step(1, 'h81, 1, 0);
    chk("R7", "second push inside interval", int'(last_ready), 0);
    for (int k = 0; k < DEPTH+2; k++) step(0, 0, 1, 1);

    // R10 refused tags never surface
    found = 0;
    foreach (seen_tags[i])
      if (seen_tags[i] == 'h33 || seen_tags[i] == 'h44 || seen_tags[i] == 'h81) found = 1;
    chk("R10", "refused tag seen at output", int'(found), 0);

    // pseudo-random mix compared against the model every cycle
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], int'(lfsr[15:8]), lfsr[1] | lfsr[2], lfsr[3] & (lfsr[4] | lfsr[5]));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule